// File: doc/BRIEF.md
# Zero-Crossing Gated Stereo Attenuator

This block scales a stereo stream of 18-bit two's-complement samples by a per-channel attenuation of 0 to 63 dB in 1 dB steps, and it can silence either channel. Each channel has a requested setting (attenuation code plus mute flag) and an applied setting. A new request is not applied at once. It is held until that channel's own signal passes through zero, so the step in gain falls where the waveform is smallest. If the signal never crosses zero, a per-channel timeout applies the request after 1024 samples.

Gain is a multiply by an unsigned Q1.15 factor taken from a 64-entry table that is computed when the design is elaborated. The product is rounded and clipped to 18 bits. A global mute input forces both outputs to zero on the very next sample, with no wait for a crossing. The stored settings are not touched by it.

Each channel runs a two-state controller. In SETTLED the request equals the applied setting. The transition *arm* (request differs and is not taken on this cycle) enters WAITING. WAITING returns to SETTLED by *cross* (the request is applied on a crossing), by *expire* (the request is applied on timeout) or by *withdraw* (the request has returned to the applied value). SETTLED also applies a request at once, with no state change, when the same cycle carries a valid sample that crosses zero.

Top module: `zc_gain_stage`

## Requirements
- R1: After reset, out_valid, out_left and out_right are 0, and both channels apply code 0 unmuted with no change pending.
- R2: A valid sample x on a channel applying code k appears one cycle later as floor((x*G[k] + 16384) / 32768), clipped to 18 bits, where G[k] = round(32768 * 10^(-k/20)). Code 0 is unity (G = 32768). out_valid is in_valid delayed by one cycle.
- R3: A pending request takes effect on the first valid sample of that channel that either equals zero or has a sign bit (bit 17) different from the previous valid sample of that channel. That sample is already scaled with the new setting. The stored previous sample is 0 after reset.
- R4: If no crossing occurs, the 1024th consecutive valid sample that sees the request pending is scaled with the new setting. The 1023 samples before it use the old setting.
- R5: The per-channel mute flag (tgt_mute_l / tgt_mute_r, 1 = mute) is gated like the attenuation code. Once applied, it makes that channel's output 0.
- R6: While mute_all is 1, every valid sample gives 0 on both outputs one cycle later. The applied settings are kept, and output resumes with them once mute_all is 0.
- R7: The two channels are independent. A request, crossing or mute on one channel leaves the other channel's output unchanged.
- R8: If the request returns to the applied setting before it is applied, nothing changes and the timeout count is cleared. A later request again waits the full 1024 samples.
- R9: Cycles with in_valid low change no state. They hold out_left and out_right, drive out_valid low, and neither count toward the timeout nor count as a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is present this cycle |
| in_left | input | 18 | Left sample, two's complement |
| in_right | input | 18 | Right sample, two's complement |
| tgt_att_l | input | 6 | Requested left attenuation code, dB |
| tgt_mute_l | input | 1 | Requested left mute |
| tgt_att_r | input | 6 | Requested right attenuation code, dB |
| tgt_mute_r | input | 1 | Requested right mute |
| mute_all | input | 1 | Immediate mute of both channels |
| out_valid | output | 1 | Output pair updated this cycle |
| out_left | output | 18 | Scaled left sample |
| out_right | output | 18 | Scaled right sample |

## Verification
The assertions assume that in_valid is held low while reset is asserted, so the first comparison with the past after reset sees a defined input. They also assume that requests are plain static levels, sampled on the same edge as the data. The bench changes requests and mute_all only on the falling clock edge, between samples, and keeps in_valid low through reset. The timeout and withdraw cases are driven with long runs of samples of one sign, so that no crossing can hide the count.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
    typedef enum logic {
        CH_SETTLED = 1'b0,
        CH_WAITING = 1'b1
    } chan_state_e;

    // Gain factor for an attenuation of k dB, unsigned Q1.15, unity = 32768
    function automatic int gain_q15(input int k);
        real v;
        v = 32768.0 * (10.0 ** (-k / 20.0));
        return $rtoi(v + 0.5);
    endfunction
endpackage

// File: rtl/zcg_gain_table.sv
module zcg_gain_table
    import zcg_pkg::*;
#(
    parameter int AW = 6,
    parameter int GW = 16
) (
    input  logic [AW-1:0] code,
    output logic [GW-1:0] gain
);
    localparam int N = 1 << AW;
    logic [GW-1:0] tbl [N];

    for (genvar k = 0; k < N; k++) begin : g_ent
        localparam logic [GW-1:0] G = GW'(gain_q15(k));
        assign tbl[k] = G;
    end

    assign gain = tbl[code];
endmodule

// File: rtl/zcg_scaler.sv
module zcg_scaler #(
    parameter int SW = 18,
    parameter int GW = 16
) (
    input  logic [SW-1:0] smp,
    input  logic [GW-1:0] gain,
    input  logic          mute,
    output logic [SW-1:0] res
);
    localparam int FRAC = GW - 1;
    localparam int PW   = SW + GW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
    localparam logic signed [PW-1:0] MAXV = PW'((1 << (SW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (SW - 1));

    logic signed [PW-1:0] prod, shr;

    always_comb begin
        prod = PW'($signed(smp)) * PW'($signed({1'b0, gain}));
        shr  = (prod + HALF) >>> FRAC;
        if (mute)
            res = '0;
        else if (shr > MAXV)
            res = MAXV[SW-1:0];
        else if (shr < MINV)
            res = MINV[SW-1:0];
        else
            res = shr[SW-1:0];
    end
endmodule

// File: rtl/zcg_chan_ctrl.sv
module zcg_chan_ctrl
    import zcg_pkg::*;
#(
    parameter int SW = 18,
    parameter int AW = 6,
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [SW-1:0] smp,
    input  logic [AW-1:0] tgt_att,
    input  logic          tgt_mute,
    output logic [AW-1:0] eff_att,
    output logic          eff_mute,
    output logic [AW-1:0] act_att,
    output logic          act_mute,
    output logic [TW-1:0] wait_cnt,
    output chan_state_e   state
);
    localparam logic [TW-1:0] CNT_LAST = '1;

    chan_state_e   st_q, st_d;
    logic [SW-1:0] prev_q;
    logic [AW-1:0] att_q;
    logic          mute_q;
    logic [TW-1:0] cnt_q;
    logic          mismatch, crossing, expire, take;

    always_comb begin
        mismatch = (tgt_att != att_q) || (tgt_mute != mute_q);
        crossing = (smp == '0) || (smp[SW-1] != prev_q[SW-1]);
        expire   = (cnt_q == CNT_LAST);
        take     = smp_valid && mismatch && (crossing || expire);
    end

    // next-state: arm / cross / expire / withdraw
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_SETTLED: if (mismatch && !take) st_d = CH_WAITING;
            CH_WAITING: if (take || !mismatch) st_d = CH_SETTLED;
            default:    st_d = CH_SETTLED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_SETTLED;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            att_q  <= '0;
            mute_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (smp_valid) prev_q <= smp;
            if (take) begin
                att_q  <= tgt_att;
                mute_q <= tgt_mute;
            end
            if (!mismatch || take) cnt_q <= '0;
            else if (smp_valid)    cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        eff_att  = take ? tgt_att  : att_q;
        eff_mute = take ? tgt_mute : mute_q;
        act_att  = att_q;
        act_mute = mute_q;
        wait_cnt = cnt_q;
        state    = st_q;
    end
endmodule

// File: rtl/zc_gain_stage.sv
module zc_gain_stage
    import zcg_pkg::*;
#(
    parameter int SW = 18,
    parameter int AW = 6,
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [SW-1:0] in_left,
    input  logic [SW-1:0] in_right,
    input  logic [AW-1:0] tgt_att_l,
    input  logic          tgt_mute_l,
    input  logic [AW-1:0] tgt_att_r,
    input  logic          tgt_mute_r,
    input  logic          mute_all,
    output logic          out_valid,
    output logic [SW-1:0] out_left,
    output logic [SW-1:0] out_right
);
    localparam int NCH = 2;
    localparam int GW  = 16;

    logic [SW-1:0] smp     [NCH];
    logic [AW-1:0] tgt_att [NCH];
    logic          tgt_mut [NCH];
    logic [AW-1:0] eff_att [NCH];
    logic          eff_mut [NCH];
    logic [AW-1:0] act_att [NCH];
    logic          act_mut [NCH];
    logic [TW-1:0] wcnt    [NCH];
    chan_state_e   cstate  [NCH];
    logic [GW-1:0] gain    [NCH];
    logic [SW-1:0] res     [NCH];

    assign smp[0]     = in_left;
    assign smp[1]     = in_right;
    assign tgt_att[0] = tgt_att_l;
    assign tgt_att[1] = tgt_att_r;
    assign tgt_mut[0] = tgt_mute_l;
    assign tgt_mut[1] = tgt_mute_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        zcg_chan_ctrl #(.SW(SW), .AW(AW), .TW(TW)) u_ctrl (
            .clk(clk), .rst_n(rst_n), .smp_valid(in_valid), .smp(smp[c]),
            .tgt_att(tgt_att[c]), .tgt_mute(tgt_mut[c]),
            .eff_att(eff_att[c]), .eff_mute(eff_mut[c]),
            .act_att(act_att[c]), .act_mute(act_mut[c]),
            .wait_cnt(wcnt[c]), .state(cstate[c])
        );
        zcg_gain_table #(.AW(AW), .GW(GW)) u_tbl (
            .code(eff_att[c]), .gain(gain[c])
        );
        zcg_scaler #(.SW(SW), .GW(GW)) u_scl (
            .smp(smp[c]), .gain(gain[c]),
            .mute(eff_mut[c] | mute_all), .res(res[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= res[0];
                out_right <= res[1];
            end
        end
    end
endmodule

// File: rtl/zc_gain_stage_chk.sv
module zc_gain_stage_chk #(
    parameter int SW = 18,
    parameter int AW = 6,
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [SW-1:0] in_left,
    input logic [SW-1:0] in_right,
    input logic [AW-1:0] tgt_att_l,
    input logic [AW-1:0] tgt_att_r,
    input logic          mute_all,
    input logic          out_valid,
    input logic [SW-1:0] out_left,
    input logic [SW-1:0] out_right,
    input logic [AW-1:0] act_att [2],
    input logic [TW-1:0] wcnt [2]
);
    function automatic logic [SW:0] mag(input logic [SW-1:0] v);
        logic signed [SW:0] s;
        s = {v[SW-1], v};
        return (s < 0) ? -s : s;
    endfunction

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right)
                      && $stable(act_att[0]) && $stable(act_att[1]));
    // R6
    global_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mute_all |=> out_left == '0 && out_right == '0);
    // R2
    no_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> mag(out_left) <= mag($past(in_left))
                     && mag(out_right) <= mag($past(in_right)));
    // R4
    expire_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && wcnt[0] == '1 && tgt_att_l != act_att[0]
        |=> act_att[0] == $past(tgt_att_l));
    // R4
    expire_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && wcnt[1] == '1 && tgt_att_r != act_att[1]
        |=> act_att[1] == $past(tgt_att_r));
endmodule

bind zc_gain_stage zc_gain_stage_chk #(.SW(SW), .AW(AW), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right),
    .tgt_att_l(tgt_att_l), .tgt_att_r(tgt_att_r), .mute_all(mute_all),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
    .act_att(act_att), .wcnt(wcnt)
);

// File: tb/tb_zc_gain_stage.sv
`timescale 1ns/1ps
module tb_zc_gain_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_left = '0, in_right = '0;
    logic [5:0]  tgt_att_l = '0, tgt_att_r = '0;
    logic        tgt_mute_l = 1'b0, tgt_mute_r = 1'b0, mute_all = 1'b0;
    logic        out_valid;
    logic [17:0] out_left, out_right;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    zc_gain_stage dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .tgt_att_l(tgt_att_l), .tgt_mute_l(tgt_mute_l),
        .tgt_att_r(tgt_att_r), .tgt_mute_r(tgt_mute_r),
        .mute_all(mute_all), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    // code (6) | sample (18)
    localparam logic [23:0] VEC [8] = '{
        {6'd0,  18'(1234)},   {6'd1,  18'(-50000)},
        {6'd6,  18'(131071)}, {6'd20, 18'(-131072)},
        {6'd40, 18'(77777)},  {6'd63, 18'(-99999)},
        {6'd3,  18'(3)},      {6'd13, 18'(-1)}
    };

    function automatic int gain_of(input int k);
        real e;
        e = -k / 20.0;
        return $rtoi(32768.0 * (10.0 ** e) + 0.5);
    endfunction

    function automatic int scale(input int x, input int k);
        longint p;
        p = longint'(x) * longint'(gain_of(k));
        return int'((p + 64'sd16384) >>> 15);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sv(input logic [17:0] v);
        return int'($signed(v));
    endfunction

    task automatic send(input int l, input int r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = 18'(l);
        in_right = 18'(r);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out_left", sv(out_left), 0);
        chk("R1 out_right", sv(out_right), 0);
        @(negedge clk);
        rst_n = 1'b1;
        send(4321, -4321);
        chk("R1 unity after reset L", sv(out_left), 4321);
        chk("R1 unity after reset R", sv(out_right), -4321);
        chk("R2 out_valid", int'(out_valid), 1);

        // R2 gain table walk, R7 right stays unity
        for (int i = 0; i < 8; i++) begin
            int code, x;
            code = int'(VEC[i][23:18]);
            x    = sv(VEC[i][17:0]);
            @(negedge clk);
            tgt_att_l = 6'(code);
            send(0, 0);
            send(x, x);
            chk("R2 table L", sv(out_left), scale(x, code));
            chk("R7 right unaffected", sv(out_right), x);
        end

        // R3 crossing gate
        tgt_att_l = 6'd0;
        send(0, 0);
        send(1000, 0);
        tgt_att_l = 6'd12;
        send(2000, 0);
        chk("R3 held", sv(out_left), 2000);
        send(3000, 0);
        chk("R3 held", sv(out_left), 3000);
        send(-500, 0);
        chk("R3 applied on crossing", sv(out_left), scale(-500, 12));

        // R4 timeout
        tgt_att_l = 6'd24;
        for (int i = 0; i < 1024; i++) begin
            send(-100, 0);
            if (i == 0 || i == 1022)
                chk("R4 old before timeout", sv(out_left), scale(-100, 12));
            if (i == 1023)
                chk("R4 forced at 1024", sv(out_left), scale(-100, 24));
        end

        // R8 withdraw clears the count
        tgt_att_l = 6'd30;
        for (int i = 0; i < 500; i++) send(-100, 0);
        chk("R8 still old", sv(out_left), scale(-100, 24));
        tgt_att_l = 6'd24;
        send(-100, 0);
        chk("R8 withdrawn", sv(out_left), scale(-100, 24));
        tgt_att_l = 6'd30;
        for (int i = 1; i <= 1024; i++) begin
            send(-100, 0);
            if (i == 1023)
                chk("R8 full wait again", sv(out_left), scale(-100, 24));
            if (i == 1024)
                chk("R8 applied after full wait", sv(out_left), scale(-100, 30));
        end

        // R5 per-channel mute, gated by crossing
        tgt_mute_r = 1'b1;
        send(-100, 4000);
        chk("R5 mute held until crossing", sv(out_right), 4000);
        send(-100, -4000);
        chk("R5 mute applied", sv(out_right), 0);
        send(-100, 6000);
        chk("R5 stays muted", sv(out_right), 0);
        chk("R7 left unaffected by right mute", sv(out_left), scale(-100, 30));

        // R6 global mute
        mute_all = 1'b1;
        send(-700, 6000);
        chk("R6 global mute L", sv(out_left), 0);
        chk("R6 global mute R", sv(out_right), 0);
        mute_all = 1'b0;
        send(-700, 6000);
        chk("R6 resume L", sv(out_left), scale(-700, 30));

        // R9 idle cycles: zero input without valid is no crossing
        tgt_att_l = 6'd40;
        in_left = '0;
        repeat (3) @(negedge clk);
        chk("R9 out_valid low", int'(out_valid), 0);
        chk("R9 output held", sv(out_left), scale(-700, 30));
        send(-100, 6000);
        chk("R9 idle zero not a crossing", sv(out_left), scale(-100, 30));

        finish_run();
    end
endmodule